// File: doc/BRIEF.md
# System Reset Control Register

This block is a byte-wide register that software writes to ask for a system reset and to choose which kind of reset follows. Each write byte is split into two fields. The request field acts on its own and is never stored. The type field is the only part the register keeps. When software writes a byte with the request bit set, the block emits a single-cycle request pulse toward the chip's reset sequencer and leaves the stored byte unchanged. Any other write replaces the stored byte with the type bit alone, and every other bit is forced to zero.

The stored type bit is also driven on a dedicated output. This lets the sequencer choose between a soft and a hard reset at the moment the pulse arrives. Reads are plain combinational views of the stored byte. Port address decoding and the sequencer itself sit outside the block. The enclosing design qualifies `wr_en` with the port address and a one-byte access size.

Control is held in a two-state machine. `ST_IDLE` is the resting state and drives no request. `ST_FIRE` drives the request pulse and lasts one cycle. The transition `T_ARM` goes from either state to `ST_FIRE` on a write with the request bit set. The transition `T_SETTLE` goes from either state to `ST_IDLE` on any other cycle. Because both transitions start from either state, two requesting writes on back-to-back cycles give a pulse two cycles long.

Top module: `sysrst_ctl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `rd_data` is 0x00, `rst_type` is 0 and `rst_req` is 0.
- R2: A write (`wr_en` = 1) with bit 2 of `wr_data` set drives `rst_req` high for the clock cycle that follows that write's sampling edge.
- R3: `rst_req` is low in every cycle that does not follow a write with bit 2 set. This includes writes with bit 2 clear.
- R4: A write with bit 2 set leaves `rd_data` unchanged, whatever value bit 1 and the other bits carry.
- R5: A write with bit 2 clear loads bit 1 of `wr_data` into bit 1 of the stored byte, visible on `rd_data` after the sampling edge.
- R6: Every bit of `rd_data` other than bit 1 reads as zero, for any written byte.
- R7: `rst_type` always equals bit 1 of `rd_data`.
- R8: In cycles with `wr_en` low, `rd_data` holds its value.
- R9: Requesting writes on consecutive cycles each produce their own pulse cycle, so `rst_req` stays high for as many cycles as there were such writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset that clears the register |
| wr_en | input | 1 | Single-byte write strobe, already qualified by the port address |
| wr_data | input | 8 | Write byte: bit 2 requests a reset, bit 1 selects the reset type |
| rd_data | output | 8 | Stored byte |
| rst_type | output | 1 | Stored reset-type select |
| rst_req | output | 1 | One-cycle reset request pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, the request field on bit 2 and the type field on bit 1. These values let an 8-bit vector table reach every combination of the two control bits while the six unused bits are set to ones. The table therefore exercises requesting writes that would change the type bit if they were stored, and plain writes whose stray ones must be dropped. Directed tests then cover back-to-back requests, idle holding and a reset applied while the type bit is set.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;

    // Control states of the request machine
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_FIRE = 1'b1
    } sysrst_state_e;

    // Decoded meaning of one bus cycle
    typedef struct packed {
        logic arm;    // write carrying the request bit
        logic load;   // write without the request bit
    } sysrst_cmd_t;

endpackage

// File: rtl/sysrst_wdec.sv
module sysrst_wdec #(
    parameter int DATA_W   = 8,
    parameter int REQ_BIT  = 2,
    parameter int TYPE_BIT = 1
) (
    input  logic                       wr_en,
    input  logic [DATA_W-1:0]          wr_data,
    output sysrst_pkg::sysrst_cmd_t    cmd,
    output logic [DATA_W-1:0]          keep_byte
);
    localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'(1) << TYPE_BIT;
    localparam logic [DATA_W-1:0] REQ_MASK  = DATA_W'(1) << REQ_BIT;

    logic req_seen;

    always_comb begin
        req_seen   = |(wr_data & REQ_MASK);
        cmd.arm    = wr_en &  req_seen;
        cmd.load   = wr_en & ~req_seen;
        keep_byte  = wr_data & KEEP_MASK;
    end
endmodule

// File: rtl/sysrst_treg.sv
module sysrst_treg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end
endmodule

// File: rtl/sysrst_fsm.sv
module sysrst_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic req
);
    import sysrst_pkg::*;

    sysrst_state_e state_q, state_d;

    // Next-state choice: T_ARM and T_SETTLE leave from either state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = arm ? ST_FIRE : ST_IDLE;
            ST_FIRE: state_d = arm ? ST_FIRE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        req = 1'b0;
        unique case (state_q)
            ST_IDLE: req = 1'b0;
            ST_FIRE: req = 1'b1;
            default: req = 1'b0;
        endcase
    end
endmodule

// File: rtl/sysrst_ctl.sv
module sysrst_ctl #(
    parameter int DATA_W   = 8,
    parameter int REQ_BIT  = 2,
    parameter int TYPE_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rst_type,
    output logic              rst_req
);
    sysrst_pkg::sysrst_cmd_t cmd;
    logic [DATA_W-1:0]       keep_byte;
    logic [DATA_W-1:0]       stored;

    sysrst_wdec #(
        .DATA_W   (DATA_W),
        .REQ_BIT  (REQ_BIT),
        .TYPE_BIT (TYPE_BIT)
    ) u_wdec (
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .cmd       (cmd),
        .keep_byte (keep_byte)
    );

    sysrst_treg #(
        .DATA_W (DATA_W)
    ) u_treg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cmd.load),
        .din   (keep_byte),
        .q     (stored)
    );

    sysrst_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (cmd.arm),
        .req   (rst_req)
    );

    assign rd_data  = stored;
    assign rst_type = stored[TYPE_BIT];
endmodule

// File: rtl/sysrst_ctl_chk.sv
module sysrst_ctl_chk #(
    parameter int DATA_W   = 8,
    parameter int REQ_BIT  = 2,
    parameter int TYPE_BIT = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              rst_type,
    input logic              rst_req
);
    localparam logic [DATA_W-1:0] OTHER_MASK = ~(DATA_W'(1) << TYPE_BIT);

    a_r2_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[REQ_BIT]) |=> rst_req);

    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_data[REQ_BIT]) |=> !rst_req);

    a_r4_request_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[REQ_BIT]) |=> $stable(rd_data));

    a_r5_type_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[REQ_BIT]) |=> (rd_data[TYPE_BIT] == $past(wr_data[TYPE_BIT])));

    a_r6_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & OTHER_MASK) == '0);

    a_r7_type_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        rst_type == rd_data[TYPE_BIT]);

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data));
endmodule

bind sysrst_ctl sysrst_ctl_chk #(
    .DATA_W   (DATA_W),
    .REQ_BIT  (REQ_BIT),
    .TYPE_BIT (TYPE_BIT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .rst_type (rst_type),
    .rst_req  (rst_req)
);

// File: tb/sysrst_ctl_test.sv
`timescale 1ns/1ps
module sysrst_ctl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       rst_type;
    logic       rst_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    sysrst_ctl uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .rst_type (rst_type),
        .rst_req  (rst_req)
    );

    // {expected rst_req, write byte, expected rd_data after the write}
    localparam logic [16:0] VEC [0:9] = '{
        {1'b0, 8'h02, 8'h02},
        {1'b1, 8'h04, 8'h02},
        {1'b1, 8'hFD, 8'h02},
        {1'b0, 8'hF9, 8'h00},
        {1'b0, 8'hFB, 8'h02},
        {1'b0, 8'h00, 8'h00},
        {1'b1, 8'h06, 8'h00},
        {1'b1, 8'hFF, 8'h00},
        {1'b0, 8'h02, 8'h02},
        {1'b0, 8'h01, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 rst_req", {7'd0, rst_req}, 8'h00);
        check("R1 rst_type", {7'd0, rst_type}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rd_data after release", rd_data, 8'h00);

        // Table walk: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < 10; i++) begin
            wr_en   = 1'b1;
            wr_data = VEC[i][15:8];
            @(negedge clk);
            wr_en = 1'b0;
            check("R4/R5/R6 rd_data", rd_data, VEC[i][7:0]);
            check("R2/R3 rst_req", {7'd0, rst_req}, {7'd0, VEC[i][16]});
            check("R7 rst_type", {7'd0, rst_type}, {7'd0, VEC[i][7:0] >> 1} & 8'h01);
            @(negedge clk);
            check("R3 rst_req after pulse", {7'd0, rst_req}, 8'h00);
        end

        // R8: idle cycles hold the stored value
        wr_en = 1'b1; wr_data = 8'h02;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
        repeat (4) @(negedge clk);
        check("R8 rd_data held", rd_data, 8'h02);

        // R9: three back-to-back requesting writes
        wr_en = 1'b1; wr_data = 8'h04;
        @(negedge clk);
        check("R9 pulse cycle 1", {7'd0, rst_req}, 8'h01);
        wr_data = 8'h00 | 8'h04;
        @(negedge clk);
        check("R9 pulse cycle 2", {7'd0, rst_req}, 8'h01);
        wr_data = 8'hFC;
        @(negedge clk);
        wr_en = 1'b0;
        check("R9 pulse cycle 3", {7'd0, rst_req}, 8'h01);
        check("R4 value after burst", rd_data, 8'h02);
        @(negedge clk);
        check("R9 pulse ends", {7'd0, rst_req}, 8'h00);

        // R1: reset while type bit is set
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 rd_data cleared", rd_data, 8'h00);
        check("R1 rst_type cleared", {7'd0, rst_type}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rst_req after reset", {7'd0, rst_req}, 8'h00);

        done = 1'b1;
        finish_run();
    end
endmodule